// File: doc/BRIEF.md
# Four-Channel Bus-Master Transfer Sequencer

This block moves blocks of memory cycles on behalf of four peripherals. The processor sets it up first. Through a byte-wide write port it loads, for each channel, a 16-bit start address and a 16-bit cycle count. The low 14 bits of the count hold the number of cycles minus one, and the top two bits hold the transfer kind. A final write to a mode register enables channels and picks fixed or rotating priority.

When an enabled channel's request, after passing a two-flop synchronizer, is seen, the block raises a hold request. It then waits for hold acknowledge before it drives the bus. Each cycle grants one channel with its active-low acknowledge, presents that channel's current address and pulses the active-low read or write strobe. A low `ready` stretches the cycle. The address then steps up by one and the count steps down by one. The final cycle raises `tc` and disables the channel. Every 128th cycle since the count was loaded raises `mark`.

The controller has five states. IDLE goes to HOLD when an enabled request is present. HOLD goes back to IDLE when the requests vanish, and to ARB once `hlda` is high. ARB picks a winner and goes to XFER, or returns to IDLE if nothing remains. XFER holds the strobe and goes to END when `ready` is high. END closes the cycle. From END the block goes to IDLE after a terminal cycle or when no request remains, to ARB if `hlda` is still high, and to HOLD otherwise.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset `hrq`, `tc` and `mark` are 0, and `dack_n`, `memr_n` and `memw_n` are all ones.
- R2: A write with `reg_sel` = 2*ch loads channel ch's address register, and `reg_sel` = 2*ch+1 loads its count register. Successive channel-register writes alternate low byte then high byte. A write to `reg_sel` = 8 sets channel enables from bits 3:0 and rotating priority from bit 4, and restarts the byte order at the low byte.
- R3: A request on an enabled channel raises `hrq` within five clocks. Requests on disabled channels are ignored, so `hrq` stays 0. `dack_n` is never active while `hrq` is low.
- R4: No acknowledge or strobe is driven until `hlda` is high.
- R5: During a cycle exactly one `dack_n` bit is low and `mem_addr` shows that channel's address. Count bits 15:14 = 10 pulse `memr_n`, 01 pulses `memw_n`, and 00 (verify) pulses neither.
- R6: The address presented rises by one from each cycle to the next.
- R7: A count value of N-1 gives exactly N cycles. `tc` is high only during the Nth, after which the channel is disabled and `hrq` drops.
- R8: `mark` is high during the 128th, 256th, … cycle counted from the count register load.
- R9: While `ready` is low the current cycle's strobe and acknowledge stay active.
- R10: In fixed priority the lowest-numbered requesting channel wins each arbitration.
- R11: In rotating priority the channel just served becomes lowest priority.
- R12: If no enabled request remains after a non-terminal cycle, `hrq` drops without `tc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one clock |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 8 | Register write byte |
| drq | input | 4 | Asynchronous channel requests |
| hlda | input | 1 | Hold acknowledge from the bus owner |
| ready | input | 1 | Low inserts wait states |
| hrq | output | 1 | Hold request |
| dack_n | output | 4 | Active-low channel acknowledges |
| mem_addr | output | 16 | Memory address of the current cycle |
| memr_n | output | 1 | Active-low memory read strobe |
| memw_n | output | 1 | Active-low memory write strobe |
| tc | output | 1 | Terminal cycle flag |
| mark | output | 1 | 128-cycle marker |

## Verification
Single-channel blocks are run with each transfer kind. These separate read, write and verify strobe selection, and confirm address stepping and terminal count for one, three, four and 256 cycles. The 256-cycle block shows that `mark` falls on cycles 128 and 256 and nowhere else. Two channels requesting together are run under fixed and then rotating priority, and the grant orders 0,0,1,1 and 0,1,0,1 tell the two modes apart. Further runs withhold `hlda`, hold `ready` low, drop a request mid-block and request on a disabled channel. These separate waiting, stretching, early release and ignoring.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 14;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HOLD,
        S_ARB,
        S_XFER,
        S_END
    } dma_state_e;

    typedef enum logic [1:0] {
        XK_VERIFY = 2'b00,
        XK_WRITE  = 2'b01,
        XK_READ   = 2'b10,
        XK_RSVD   = 2'b11
    } xfer_kind_e;
endpackage

// File: rtl/dma4_req_sync.sv
module dma4_req_sync #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_async,
    output logic [NCH-1:0] req_sync
);
    for (genvar g = 0; g < NCH; g++) begin : g_sync
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= req_async[g];
                s2_q <= s1_q;
            end
        end
        assign req_sync[g] = s2_q;
    end
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    input  logic           rotate,
    input  logic [CHW-1:0] last_ch,
    output logic           any,
    output logic [CHW-1:0] win
);
    logic [CHW-1:0] base;

    always_comb begin
        if (!rotate)
            base = '0;
        else if (int'(last_ch) == NCH - 1)
            base = '0;
        else
            base = last_ch + 1'b1;
    end

    always_comb begin
        any = 1'b0;
        win = '0;
        for (int i = 0; i < NCH; i++) begin
            int idx;
            idx = (int'(base) + i) % NCH;
            if (!any && req[idx]) begin
                any = 1'b1;
                win = CHW'(idx);
            end
        end
    end
endmodule

// File: rtl/dma4_regs.sv
module dma4_regs
    import dma4_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int MARK_W = 7,
    localparam int CHW      = $clog2(NCH),
    localparam int MODE_SEL = 2 * NCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [3:0]        wsel,
    input  logic [7:0]        wdata,
    input  logic              upd,
    input  logic [CHW-1:0]    sel,
    output logic [NCH-1:0]    en_o,
    output logic              rot_o,
    output logic [ADDR_W-1:0] cur_addr,
    output xfer_kind_e        cur_kind,
    output logic              cur_last,
    output logic              cur_mark
);
    logic [ADDR_W-1:0] addr_q [NCH];
    logic [15:0]       cnt_q  [NCH];
    logic [MARK_W-1:0] elap_q [NCH];
    logic [NCH-1:0]    en_q;
    logic              rot_q;
    logic              hi_q;
    logic [CHW-1:0]    wch;

    assign wch = wsel[CHW:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                addr_q[i] <= '0;
                cnt_q[i]  <= '0;
                elap_q[i] <= '0;
            end
            en_q  <= '0;
            rot_q <= 1'b0;
            hi_q  <= 1'b0;
        end else begin
            if (wr && int'(wsel) == MODE_SEL) begin
                en_q  <= wdata[NCH-1:0];
                rot_q <= wdata[NCH];
                hi_q  <= 1'b0;
            end else if (wr && int'(wsel) < MODE_SEL) begin
                hi_q <= ~hi_q;
                if (!wsel[0]) begin
                    if (hi_q) addr_q[wch][15:8] <= wdata;
                    else      addr_q[wch][7:0]  <= wdata;
                end else begin
                    if (hi_q) cnt_q[wch][15:8] <= wdata;
                    else      cnt_q[wch][7:0]  <= wdata;
                    elap_q[wch] <= '0;
                end
            end
            if (upd) begin
                addr_q[sel]            <= addr_q[sel] + 1'b1;
                cnt_q[sel][CNT_W-1:0]  <= cnt_q[sel][CNT_W-1:0] - 1'b1;
                elap_q[sel]            <= elap_q[sel] + 1'b1;
                if (cnt_q[sel][CNT_W-1:0] == '0)
                    en_q[sel] <= 1'b0;
            end
        end
    end

    assign en_o     = en_q;
    assign rot_o    = rot_q;
    assign cur_addr = addr_q[sel];
    assign cur_kind = xfer_kind_e'(cnt_q[sel][15:14]);
    assign cur_last = (cnt_q[sel][CNT_W-1:0] == '0);
    assign cur_mark = (elap_q[sel] == '1);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R6
        addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && int'(sel) == g && !wr) |=> (addr_q[g] == $past(addr_q[g]) + 1'b1));
        // R7
        tc_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && int'(sel) == g && cnt_q[g][CNT_W-1:0] == '0 && !wr) |=> !en_q[g]);
    end
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int MARK_W = 7,
    localparam int CHW   = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic [NCH-1:0]    drq,
    input  logic              hlda,
    input  logic              ready,
    output logic              hrq,
    output logic [NCH-1:0]    dack_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              memr_n,
    output logic              memw_n,
    output logic              tc,
    output logic              mark
);
    dma_state_e        state_q, state_d;
    logic [CHW-1:0]    cur_q, last_q;
    logic [NCH-1:0]    req_s, en, req_live;
    logic              rot, arb_any;
    logic [CHW-1:0]    arb_win;
    logic [ADDR_W-1:0] cur_addr;
    xfer_kind_e        cur_kind;
    logic              cur_last, cur_mark;
    logic              upd;

    dma4_req_sync #(.NCH(NCH)) u_sync (
        .clk(clk), .rst_n(rst_n), .req_async(drq), .req_sync(req_s)
    );

    assign req_live = req_s & en;

    dma4_arb #(.NCH(NCH)) u_arb (
        .req(req_live), .rotate(rot), .last_ch(last_q), .any(arb_any), .win(arb_win)
    );

    dma4_regs #(.NCH(NCH), .MARK_W(MARK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wsel(reg_sel), .wdata(reg_wdata),
        .upd(upd), .sel(cur_q), .en_o(en), .rot_o(rot), .cur_addr(cur_addr),
        .cur_kind(cur_kind), .cur_last(cur_last), .cur_mark(cur_mark)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (|req_live) state_d = S_HOLD;
            S_HOLD: begin
                if (!(|req_live)) state_d = S_IDLE;
                else if (hlda)    state_d = S_ARB;
            end
            S_ARB:  state_d = arb_any ? S_XFER : S_IDLE;
            S_XFER: if (ready) state_d = S_END;
            S_END: begin
                if (cur_last || !(|req_live)) state_d = S_IDLE;
                else if (hlda)                state_d = S_ARB;
                else                          state_d = S_HOLD;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            last_q  <= CHW'(NCH - 1);
        end else begin
            state_q <= state_d;
            if (state_q == S_ARB && arb_any) cur_q  <= arb_win;
            if (state_q == S_END)            last_q <= cur_q;
        end
    end

    always_comb begin
        hrq      = (state_q != S_IDLE);
        dack_n   = '1;
        mem_addr = '0;
        memr_n   = 1'b1;
        memw_n   = 1'b1;
        tc       = 1'b0;
        mark     = 1'b0;
        upd      = 1'b0;
        if (state_q == S_XFER || state_q == S_END) begin
            dack_n[cur_q] = 1'b0;
            mem_addr      = cur_addr;
        end
        if (state_q == S_XFER) begin
            memr_n = !(cur_kind == XK_READ);
            memw_n = !(cur_kind == XK_WRITE);
        end
        if (state_q == S_END) begin
            tc   = cur_last;
            mark = cur_mark;
            upd  = 1'b1;
        end
    end

    // R5
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~dack_n));
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!memr_n && !memw_n));
    // R4
    grant_after_hlda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARB) |-> $past(hlda));
    // R9
    ready_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_XFER && !ready) |=> (state_q == S_XFER));
    // R7
    tc_release_chk: assert property (@(posedge clk) disable iff (!rst_n) tc |=> !hrq);
    // R3
    no_hold_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) !hrq |-> (&dack_n));
endmodule

// File: tb/test_dma4_ctrl.sv
module test_dma4_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [3:0]  drq = '0;
    logic        hlda = 1'b0;
    logic        ready = 1'b1;
    logic        hrq, memr_n, memw_n, tc, mark;
    logic [3:0]  dack_n;
    logic [15:0] mem_addr;

    int checks = 0, errors = 0, cyc = 0;
    bit auto_hlda = 1'b1;
    int nxfer, ntc, tc_at, nmark, nrd, nwr, bad_ack;
    int order [16];
    int addrs [16];
    int mark_at [4];
    logic [3:0] prev_dack = '1;

    always #2 clk = ~clk;

    dma4_ctrl i_dma4_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .drq(drq), .hlda(hlda), .ready(ready), .hrq(hrq), .dack_n(dack_n),
        .mem_addr(mem_addr), .memr_n(memr_n), .memw_n(memw_n), .tc(tc), .mark(mark)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (dack_n != 4'hF && !hlda) bad_ack++;
            if (dack_n != 4'hF && prev_dack == 4'hF) begin
                if (nxfer < 16) begin
                    for (int i = 0; i < 4; i++) if (!dack_n[i]) order[nxfer] = i;
                    addrs[nxfer] = int'(mem_addr);
                end
                nxfer++;
            end
            if (tc) begin ntc++; tc_at = nxfer; end
            if (mark) begin
                if (nmark < 4) mark_at[nmark] = nxfer;
                nmark++;
            end
            if (!memr_n) nrd++;
            if (!memw_n) nwr++;
            prev_dack = dack_n;
        end
        hlda = auto_hlda ? hrq : 1'b0;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nxfer = 0; ntc = 0; tc_at = -1; nmark = 0; nrd = 0; nwr = 0; bad_ack = 0;
        for (int i = 0; i < 16; i++) begin order[i] = -1; addrs[i] = -1; end
        for (int i = 0; i < 4; i++) mark_at[i] = -1;
    endtask

    task automatic wr_reg(input int sel, input int data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 4'(sel); reg_wdata = 8'(data);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_mode(input int en, input bit rot);
        wr_reg(8, en | (int'(rot) << 4));
    endtask

    task automatic prog(input int ch, input int addr, input int cnt);
        set_mode(0, 1'b0);
        wr_reg(2 * ch, addr & 8'hFF);
        wr_reg(2 * ch, (addr >> 8) & 8'hFF);
        wr_reg(2 * ch + 1, cnt & 8'hFF);
        wr_reg(2 * ch + 1, (cnt >> 8) & 8'hFF);
    endtask

    task automatic wait_done();
        int quiet = 0;
        for (int i = 0; i < 5000 && quiet < 10; i++) begin
            @(negedge clk);
            quiet = hrq ? 0 : quiet + 1;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(hrq == 0 && tc == 0 && mark == 0, "R1 flags", int'(hrq), 0);
        chk(dack_n == 4'hF && memr_n && memw_n, "R1 strobes", int'(dack_n), 15);
    endtask

    task automatic t_disabled();
        clear_mon();
        prog(1, 16'h0040, 16'h8000);
        drq[1] = 1'b1;
        repeat (20) @(negedge clk);
        chk(hrq == 0, "R3 disabled channel ignored hrq", int'(hrq), 0);
        chk(nxfer == 0, "R3 disabled channel no cycles", nxfer, 0);
        drq[1] = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_hold_read();
        clear_mon();
        auto_hlda = 1'b0;
        wr_reg(0, 8'hEE);
        prog(0, 16'h1230, 16'h8002);
        set_mode(1, 1'b0);
        drq[0] = 1'b1;
        repeat (5) @(negedge clk);
        chk(hrq == 1, "R3 hrq raised", int'(hrq), 1);
        repeat (20) @(negedge clk);
        chk(nxfer == 0 && dack_n == 4'hF, "R4 no grant without hlda", nxfer, 0);
        auto_hlda = 1'b1;
        wait_done();
        chk(nxfer == 3, "R7 three cycles", nxfer, 3);
        chk(ntc == 1 && tc_at == 3, "R7 tc on last", tc_at, 3);
        chk(addrs[0] == 'h1230, "R2 byte order address", addrs[0], 'h1230);
        chk(addrs[1] == 'h1231 && addrs[2] == 'h1232, "R6 address steps", addrs[2], 'h1232);
        chk(nrd == 3 && nwr == 0, "R5 read strobes", nrd, 3);
        chk(order[0] == 0 && order[2] == 0, "R5 channel 0 ack", order[2], 0);
        chk(bad_ack == 0, "R4 ack only with hlda", bad_ack, 0);
        repeat (10) @(negedge clk);
        chk(hrq == 0, "R7 channel disabled after tc", int'(hrq), 0);
        drq[0] = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_write_one();
        clear_mon();
        prog(3, 16'hFFFF, 16'h4000);
        set_mode(8, 1'b0);
        drq[3] = 1'b1;
        wait_done();
        chk(nxfer == 1 && tc_at == 1, "R7 single cycle", nxfer, 1);
        chk(nwr == 1 && nrd == 0, "R5 write strobe", nwr, 1);
        chk(addrs[0] == 'hFFFF && order[0] == 3, "R5 channel 3 address", addrs[0], 'hFFFF);
        drq[3] = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_verify();
        clear_mon();
        prog(2, 16'h0500, 16'h0003);
        set_mode(4, 1'b0);
        drq[2] = 1'b1;
        wait_done();
        chk(nxfer == 4 && ntc == 1, "R7 four verify cycles", nxfer, 4);
        chk(nrd == 0 && nwr == 0, "R5 verify no strobes", nrd + nwr, 0);
        drq[2] = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_ready();
        clear_mon();
        ready = 1'b0;
        prog(1, 16'h0777, 16'h8000);
        set_mode(2, 1'b0);
        drq[1] = 1'b1;
        repeat (30) @(negedge clk);
        chk(nxfer == 1 && memr_n == 0 && dack_n == 4'b1101, "R9 cycle stretched", int'(memr_n), 0);
        chk(ntc == 0, "R9 no tc while waiting", ntc, 0);
        ready = 1'b1;
        wait_done();
        chk(ntc == 1 && nrd > 20, "R9 completes after ready", nrd, 21);
        drq[1] = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_mark();
        clear_mon();
        prog(0, 16'h2000, 16'h40FF);
        set_mode(1, 1'b0);
        drq[0] = 1'b1;
        wait_done();
        chk(nxfer == 256 && tc_at == 256, "R7 256 cycles", tc_at, 256);
        chk(nmark == 2, "R8 two marks", nmark, 2);
        chk(mark_at[0] == 128 && mark_at[1] == 256, "R8 mark positions", mark_at[0], 128);
        drq[0] = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_pair(input bit rot);
        clear_mon();
        prog(0, 16'h0100, 16'h8001);
        prog(1, 16'h0200, 16'h8001);
        set_mode(3, rot);
        drq[1:0] = 2'b11;
        wait_done();
        chk(nxfer == 4 && ntc == 2, "R10 R11 four cycles", nxfer, 4);
        if (!rot)
            chk(order[0] == 0 && order[1] == 0 && order[2] == 1 && order[3] == 1,
                "R10 fixed order", order[1], 0);
        else
            chk(order[0] == 0 && order[1] == 1 && order[2] == 0 && order[3] == 1,
                "R11 rotating order", order[1], 1);
        drq[1:0] = 2'b00;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_drop();
        clear_mon();
        prog(2, 16'h0900, 16'h8009);
        set_mode(4, 1'b0);
        drq[2] = 1'b1;
        for (int i = 0; i < 200 && nxfer < 2; i++) @(negedge clk);
        drq[2] = 1'b0;
        wait_done();
        chk(hrq == 0 && ntc == 0, "R12 release without tc", ntc, 0);
        chk(nxfer >= 2 && nxfer < 10, "R12 block cut short", nxfer, 4);
    endtask

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_disabled();
        t_hold_read();
        t_write_one();
        t_verify();
        t_ready();
        t_mark();
        t_pair(1'b0);
        t_pair(1'b1);
        t_drop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule